// File: doc/BRIEF.md
# Clock Source Switch Controller

This block picks the master clock of a small controller from four oscillators: an external crystal, an externally driven user clock, a 16 MHz internal RC and a 128 kHz low-speed RC. It passes the chosen clock through a power-of-two prescaler and also holds the clock-enable bits for the peripherals. Software asks for a new source by writing a register. The block waits until that source says it is ready, then hands the clock over from the old source to the new one. It does this without truncating any high or low phase.

A security monitor can watch whichever external clock is in use. If no edge of that clock arrives within a fixed number of low-speed RC periods, the block marks a fault and puts the failed clock path into reset. It then switches back to the reset default, the internal RC divided by 8, and can raise an interrupt. The control logic and the register port run on the internal RC clock, which is assumed to run at all times.

Top module: `clksw_top`

## Requirements
- R1: Source codes are 0 = internal RC, 1 = low-speed RC, 2 = crystal, 3 = external user clock. `cur_src` shows the committed source. Once settled, the period of `mclk` equals the period of that source times 2^n, where n is the prescaler field.
- R2: After reset, `cur_src` = 0, n = 3, `sw_busy` = 0, `css_fault` = 0, `css_irq` = 0 and `per_clk_en` is all ones. So `mclk` is the internal RC divided by 8.
- R3: A write to address 0 with a code different from `cur_src` (code in bits 1:0) sets `sw_busy`. While the target's ready input is low, `cur_src` and `mclk` stay unchanged. `cur_src` changes only in the cycle where `sw_busy` falls.
- R4: During a handover, no more than one source path drives `mclk` at any time. No high or low phase of `mclk` is shorter than half the shortest source period, provided the prescaler setting stays fixed during the handover.
- R5: While `sw_busy` is 1, writes to address 0 are ignored. A write to address 0 that names the current source does not start a switch.
- R6: A write to address 1 sets the prescaler field n from bits 2:0. `mclk` then divides the selected source by 2^n, for n from 0 to 7.
- R7: Address 2 bit 0 enables the monitor. When it is set and the committed source is 2 or 3, the absence of edges on that clock for CSS_LRC_CYCLES low-speed RC periods does three things: it sets `css_fault`, it switches to source 0, and it forces n to 3. With bit 0 clear, a stopped external clock sets no fault.
- R8: `css_irq` equals `css_fault` AND address 2 bit 1. A write to address 2 with bit 2 set clears `css_fault`. The same write also loads bits 1:0.
- R9: A write to address 3 loads `per_clk_en` with the eight data bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_hrc | input | 1 | Internal 16 MHz RC clock; also clocks the control and register port |
| clk_lrc | input | 1 | Internal low-speed RC clock |
| clk_xtal | input | 1 | External crystal clock |
| clk_ext | input | 1 | External user clock |
| rst_n | input | 1 | Active-low reset |
| rdy_hrc | input | 1 | Internal RC ready |
| rdy_lrc | input | 1 | Low-speed RC ready |
| rdy_xtal | input | 1 | Crystal ready |
| rdy_ext | input | 1 | External clock ready |
| wr_en | input | 1 | Register write strobe (clk_hrc domain) |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| mclk | output | 1 | Master clock after source mux and prescaler |
| per_clk_en | output | 8 | Peripheral clock enables |
| cur_src | output | 2 | Committed source code |
| sw_busy | output | 1 | Source switch in progress |
| css_fault | output | 1 | External clock failure detected |
| css_irq | output | 1 | Failure interrupt request |

## Verification
The hardest case to reach is the loss of a running external clock. The monitor is only armed while the block sits idle on that source, and recovery depends on the dead path being forced off, because its own clock can no longer turn it off. The bench stops its crystal or external clock generator partway through a run, after a clean switch onto that source. It then checks the fault, the interrupt, the return to the internal RC divided by 8, and that the same source can be used again after the fault is cleared. A chain of handovers through all four sources runs while a monitor records the shortest phase of `mclk`.

// File: rtl/clksw_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the clock source switch controller.
package clksw_pkg;
    localparam int NSRC   = 4;   // number of master clock sources
    localparam int SEL_W  = 2;   // source code width
    localparam int DIV_W  = 3;   // prescaler exponent width
    localparam int DATA_W = 8;   // register write data width
    localparam int ADDR_W = 2;   // register address width

    typedef enum logic [SEL_W-1:0] {
        SRC_HRC  = 2'd0,
        SRC_LRC  = 2'd1,
        SRC_XTAL = 2'd2,
        SRC_EXT  = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WAIT_RDY = 2'd1,
        ST_HANDOVER = 2'd2
    } sw_st_e;

    localparam logic [ADDR_W-1:0] A_SRC = 2'd0;
    localparam logic [ADDR_W-1:0] A_DIV = 2'd1;
    localparam logic [ADDR_W-1:0] A_CSS = 2'd2;
    localparam logic [ADDR_W-1:0] A_PER = 2'd3;

    localparam logic [DIV_W-1:0] DIV_RST = 3'd3;

    // One-hot vector for a source code.
    function automatic logic [NSRC-1:0] src_onehot(input src_e s);
        return {{(NSRC-1){1'b0}}, 1'b1} << s;
    endfunction
endpackage

// File: rtl/clksw_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer, W bits wide, rising edge.
// Assumes each bit is independent or changes rarely relative to clk.
module clksw_sync #(
    parameter int W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Bring d into the clk domain through two stages.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/clksw_leg.sv
`timescale 1ns/1ps
// One source path of the glitch-free clock mux.
// The enable passes through two flops on the falling edge of this path's
// own clock. The gate therefore opens and closes only while the clock is
// low. The path enables only when no other path is on. arst_n also clears
// the path when its clock has died.
module clksw_leg (
    input  logic clk,
    input  logic arst_n,
    input  logic want,
    input  logic others_on,
    output logic on,
    output logic gclk
);
    logic s1;

    // Synchronize the enable request on this clock's falling edge.
    always_ff @(negedge clk or negedge arst_n) begin
        if (!arst_n) begin
            s1 <= 1'b0;
            on <= 1'b0;
        end else begin
            s1 <= want & ~others_on;
            on <= s1;
        end
    end

    assign gclk = clk & on;
endmodule

// File: rtl/clksw_css.sv
`timescale 1ns/1ps
// External clock failure monitor, run in the internal RC domain.
// Each external clock toggles a flag. The flag and the low-speed RC are
// synchronized here. A counter counts low-speed RC rising edges since the
// last flag change and trips at LIMIT. Assumes clk is faster than twice
// each monitored clock's toggle rate.
module clksw_css #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_xtal,
    input  logic clk_ext,
    input  logic clk_lrc,
    input  logic arm,
    input  logic watch_ext,
    output logic trip
);
    localparam int CNT_W = $clog2(LIMIT + 1);

    logic             tog_x, tog_e;
    logic [2:0]       smp;
    logic             lrc_prev, mon_prev;
    logic [CNT_W-1:0] cnt;
    logic             mon, lrc_rise, mon_edge;

    // Toggle on every crystal edge.
    always_ff @(posedge clk_xtal or negedge rst_n) begin
        if (!rst_n) tog_x <= 1'b0;
        else        tog_x <= ~tog_x;
    end

    // Toggle on every external user clock edge.
    always_ff @(posedge clk_ext or negedge rst_n) begin
        if (!rst_n) tog_e <= 1'b0;
        else        tog_e <= ~tog_e;
    end

    clksw_sync #(.W(3)) u_smp (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({clk_lrc, tog_e, tog_x}),
        .q    (smp)
    );

    assign mon      = watch_ext ? smp[1] : smp[0];
    assign lrc_rise = smp[2] & ~lrc_prev;
    assign mon_edge = mon ^ mon_prev;
    assign trip     = arm && lrc_rise && !mon_edge &&
                      (cnt == CNT_W'(LIMIT - 1));

    // Remember last samples for edge detection.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lrc_prev <= 1'b0;
            mon_prev <= 1'b0;
        end else begin
            lrc_prev <= smp[2];
            mon_prev <= mon;
        end
    end

    // Count low-speed periods without a monitored edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt <= '0;
        else if (!arm || mon_edge)  cnt <= '0;
        else if (lrc_rise && !trip) cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/clksw_div.sv
`timescale 1ns/1ps
// Master prescaler: divides the muxed clock by 2^n for n = 0..2^DIV_W-1.
// For n > 0 the output is a toggling flop. For n = 0 the raw clock is
// passed through. The exponent is re-synchronized into the raw domain.
module clksw_div
    import clksw_pkg::*;
(
    input  logic             clk_raw,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             mclk
);
    localparam int LIM_W = 1 << DIV_W;

    logic [DIV_W-1:0] d_s;
    logic [LIM_W-1:0] cnt, half;
    logic             q;

    clksw_sync #(.W(DIV_W), .RST_VAL(DIV_RST)) u_dsync (
        .clk  (clk_raw),
        .rst_n(rst_n),
        .d    (div),
        .q    (d_s)
    );

    assign half = (LIM_W'(1) << d_s) >> 1;

    // Count half periods and toggle the divided output.
    always_ff @(posedge clk_raw or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            q   <= 1'b0;
        end else if (d_s == '0) begin
            cnt <= '0;
            q   <= 1'b0;
        end else if (cnt >= half - LIM_W'(1)) begin
            cnt <= '0;
            q   <= ~q;
        end else begin
            cnt <= cnt + LIM_W'(1);
        end
    end

    assign mclk = (d_s == '0) ? clk_raw : q;
endmodule

// File: rtl/clksw_ctrl.sv
`timescale 1ns/1ps
// Switch engine and configuration registers, internal RC domain.
// Assumes ready flags and path-on flags arrive already synchronized.
// It sequences a request as: wait for ready, move the enable, wait until
// only the target path is on, commit. A monitor trip forces a fallback.
module clksw_ctrl
    import clksw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [NSRC-1:0]   rdy_s,
    input  logic [NSRC-1:0]   on_s,
    input  logic              css_trip,
    output logic [NSRC-1:0]   want,
    output logic [NSRC-1:0]   kill,
    output src_e              cur,
    output src_e              tgt,
    output logic              busy,
    output logic [DIV_W-1:0]  div_q,
    output logic              css_arm,
    output logic              css_fault,
    output logic              css_irq,
    output logic [DATA_W-1:0] per_en
);
    sw_st_e st;
    logic   css_en, irq_en;
    logic   wr_src, wr_div, wr_css, wr_per, clr;

    assign wr_src = wr_en && (wr_addr == A_SRC);
    assign wr_div = wr_en && (wr_addr == A_DIV);
    assign wr_css = wr_en && (wr_addr == A_CSS);
    assign wr_per = wr_en && (wr_addr == A_PER);
    assign clr    = wr_css && wr_data[2];

    // Switch sequencing, prescaler field and failure latching.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            cur   <= SRC_HRC;
            tgt   <= SRC_HRC;
            want  <= src_onehot(SRC_HRC);
            div_q <= DIV_RST;
            kill  <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (css_trip) begin
                        kill <= src_onehot(cur);
                        tgt  <= SRC_HRC;
                        st   <= ST_WAIT_RDY;
                    end else if (wr_src && (wr_data[SEL_W-1:0] != cur)) begin
                        tgt <= src_e'(wr_data[SEL_W-1:0]);
                        st  <= ST_WAIT_RDY;
                    end
                end
                ST_WAIT_RDY: begin
                    if (rdy_s[tgt]) begin
                        want <= src_onehot(tgt);
                        st   <= ST_HANDOVER;
                    end
                end
                ST_HANDOVER: begin
                    if (on_s == src_onehot(tgt)) begin
                        cur <= tgt;
                        st  <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
            if (css_trip)     div_q <= DIV_RST;
            else if (wr_div)  div_q <= wr_data[DIV_W-1:0];
            if (clr && !css_trip) kill <= '0;
        end
    end

    // Plain configuration bits: monitor enables and peripheral gates.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            css_en <= 1'b0;
            irq_en <= 1'b0;
            per_en <= '1;
        end else begin
            if (wr_css) begin
                css_en <= wr_data[0];
                irq_en <= wr_data[1];
            end
            if (wr_per) per_en <= wr_data;
        end
    end

    assign busy      = (st != ST_IDLE);
    assign css_arm   = (st == ST_IDLE) && css_en && cur[1];
    assign css_fault = |kill;
    assign css_irq   = css_fault && irq_en;
endmodule

// File: rtl/clksw_top.sv
`timescale 1ns/1ps
// Clock source switch controller top.
// Four per-source gated paths form a glitch-free mux, which feeds a
// power-of-two prescaler. Control, registers and the failure monitor run
// on clk_hrc, which is assumed to be always running.
module clksw_top #(
    parameter int CSS_LRC_CYCLES = 4
) (
    input  logic       clk_hrc,
    input  logic       clk_lrc,
    input  logic       clk_xtal,
    input  logic       clk_ext,
    input  logic       rst_n,
    input  logic       rdy_hrc,
    input  logic       rdy_lrc,
    input  logic       rdy_xtal,
    input  logic       rdy_ext,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    output logic       mclk,
    output logic [7:0] per_clk_en,
    output logic [1:0] cur_src,
    output logic       sw_busy,
    output logic       css_fault,
    output logic       css_irq
);
    import clksw_pkg::*;

    logic [NSRC-1:0]  src_clk, rdy_raw, rdy_s, on_s;
    logic [NSRC-1:0]  want, kill, leg_on, gclk;
    src_e             cur_e, tgt_e;
    logic [1:0]       tgt_src;
    logic [DIV_W-1:0] div_q;
    logic             css_arm, css_trip, mclk_raw;

    assign src_clk = {clk_ext, clk_xtal, clk_lrc, clk_hrc};
    assign rdy_raw = {rdy_ext, rdy_xtal, rdy_lrc, rdy_hrc};

    clksw_sync #(.W(2 * NSRC)) u_stat_sync (
        .clk  (clk_hrc),
        .rst_n(rst_n),
        .d    ({leg_on, rdy_raw}),
        .q    ({on_s, rdy_s})
    );

    clksw_ctrl u_ctrl (
        .clk      (clk_hrc),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rdy_s    (rdy_s),
        .on_s     (on_s),
        .css_trip (css_trip),
        .want     (want),
        .kill     (kill),
        .cur      (cur_e),
        .tgt      (tgt_e),
        .busy     (sw_busy),
        .div_q    (div_q),
        .css_arm  (css_arm),
        .css_fault(css_fault),
        .css_irq  (css_irq),
        .per_en   (per_clk_en)
    );

    clksw_css #(.LIMIT(CSS_LRC_CYCLES)) u_css (
        .clk      (clk_hrc),
        .rst_n    (rst_n),
        .clk_xtal (clk_xtal),
        .clk_ext  (clk_ext),
        .clk_lrc  (clk_lrc),
        .arm      (css_arm),
        .watch_ext(cur_e[0]),
        .trip     (css_trip)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_leg
        logic leg_rst_n;
        assign leg_rst_n = rst_n & ~kill[i];
        clksw_leg u_leg (
            .clk      (src_clk[i]),
            .arst_n   (leg_rst_n),
            .want     (want[i]),
            .others_on(|(leg_on & ~(NSRC'(1) << i))),
            .on       (leg_on[i]),
            .gclk     (gclk[i])
        );
    end

    assign mclk_raw = |gclk;

    clksw_div u_div (
        .clk_raw(mclk_raw),
        .rst_n  (rst_n),
        .div    (div_q),
        .mclk   (mclk)
    );

    assign cur_src = cur_e;
    assign tgt_src = tgt_e;
endmodule

// File: rtl/clksw_chk.sv
`timescale 1ns/1ps
// Assertion checker for clksw_top, attached by bind.
module clksw_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [1:0] wr_addr,
    input logic       sw_busy,
    input logic [1:0] cur_src,
    input logic [1:0] tgt_src,
    input logic [3:0] leg_on,
    input logic [2:0] div_q,
    input logic       css_fault,
    input logic       css_irq
);
    // R5
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_busy && wr_en && wr_addr == 2'd0) |=> $stable(tgt_src));

    // R3
    commit_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_src) |-> $fell(sw_busy));

    // R4
    single_leg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(leg_on));

    // R7
    fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(css_fault) |-> (tgt_src == 2'd0 && sw_busy && div_q == 3'd3));

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        css_irq |-> css_fault);
endmodule

bind clksw_top clksw_chk u_chk (
    .clk      (clk_hrc),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .sw_busy  (sw_busy),
    .cur_src  (cur_src),
    .tgt_src  (tgt_src),
    .leg_on   (leg_on),
    .div_q    (div_q),
    .css_fault(css_fault),
    .css_irq  (css_irq)
);

// File: tb/sim_clksw_top.sv
`timescale 1ns/1ps
module sim_clksw_top;
    localparam int CLK_PERIOD  = 10;   // internal RC, control clock
    localparam int LRC_PERIOD  = 160;
    localparam int XTAL_PERIOD = 14;
    localparam int EXT_PERIOD  = 22;
    localparam int MAX_CYCLES  = 150000;

    logic clk_hrc = 0, clk_lrc = 0, clk_xtal = 0, clk_ext = 0;
    logic rst_n = 0;
    logic rdy_hrc = 1, rdy_lrc = 1, rdy_xtal = 0, rdy_ext = 1;
    logic wr_en = 0;
    logic [1:0] wr_addr = 0;
    logic [7:0] wr_data = 0;
    logic mclk, sw_busy, css_fault, css_irq;
    logic [7:0] per_clk_en;
    logic [1:0] cur_src;
    logic xtal_run = 1, ext_run = 1;

    int checks = 0, fails = 0;
    logic watch = 0;
    longint last_edge = 0, min_ph = 1000000;

    clksw_top u0 (.*);

    always #(CLK_PERIOD/2) clk_hrc = ~clk_hrc;
    always #(LRC_PERIOD/2) clk_lrc = ~clk_lrc;
    always #(XTAL_PERIOD/2) clk_xtal = xtal_run ? ~clk_xtal : 1'b0;
    always #(EXT_PERIOD/2) clk_ext = ext_run ? ~clk_ext : 1'b0;

    // Shortest phase of mclk while watching.
    always @(mclk) begin
        if (watch && ($time - last_edge) < min_ph) min_ph = $time - last_edge;
        last_edge = $time;
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk_hrc);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk_hrc);
        wr_en = 0;
    endtask

    task automatic wait_idle();
        for (int n = 0; n < 3000 && sw_busy; n++) @(negedge clk_hrc);
        repeat (4) @(negedge clk_hrc);
    endtask

    task automatic measure(output longint per);
        longint t0;
        repeat (3) @(posedge mclk);
        t0 = $time;
        @(posedge mclk);
        per = $time - t0;
    endtask

    function automatic longint exp_per(input int src, input int dv);
        longint b;
        case (src)
            0: b = CLK_PERIOD;
            1: b = LRC_PERIOD;
            2: b = XTAL_PERIOD;
            default: b = EXT_PERIOD;
        endcase
        return b << dv;
    endfunction

    initial begin
        #(longint'(CLK_PERIOD) * MAX_CYCLES);
        fails++; checks++;
        $display("FAIL watchdog all requirements actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        longint per;
        int cur_exp, seed, s, dv;
        logic [7:0] pv;
        seed = $urandom(32'd4242);
        repeat (5) @(negedge clk_hrc);
        rst_n = 1;
        repeat (20) @(negedge clk_hrc);

        // R2 reset state
        chk("R2 cur_src", cur_src, 0);
        chk("R2 sw_busy", sw_busy, 0);
        chk("R2 css_fault", css_fault, 0);
        chk("R2 css_irq", css_irq, 0);
        chk("R2 per_clk_en", per_clk_en, 8'hFF);
        measure(per);
        chk("R2 reset mclk period", per, exp_per(0, 3));

        // R3 request held until crystal ready
        wr(2'd0, 8'd2);
        repeat (60) @(negedge clk_hrc);
        chk("R3 busy while not ready", sw_busy, 1);
        chk("R3 cur_src unchanged", cur_src, 0);
        measure(per);
        chk("R3 mclk unchanged", per, exp_per(0, 3));

        // R5 request while busy ignored
        wr(2'd0, 8'd3);
        rdy_xtal = 1;
        wait_idle();
        chk("R5 busy request ignored", cur_src, 2);
        measure(per);
        chk("R1 crystal period", per, exp_per(2, 3));
        wr(2'd0, 8'd2);
        @(negedge clk_hrc);
        chk("R5 same source no switch", sw_busy, 0);

        // R6 directed extremes on internal RC
        wr(2'd0, 8'd0); wait_idle();
        wr(2'd1, 8'd0); repeat (10) @(negedge clk_hrc);
        measure(per);
        chk("R6 n=0", per, exp_per(0, 0));
        wr(2'd1, 8'd7); repeat (10) @(negedge clk_hrc);
        measure(per);
        chk("R6 n=7", per, exp_per(0, 7));

        // R4 handover chain with fixed bypass prescaler
        wr(2'd1, 8'd0); repeat (20) @(negedge clk_hrc);
        min_ph = 1000000; watch = 1;
        for (int k = 1; k <= 4; k++) begin
            wr(2'd0, 8'(k % 4)); wait_idle();
            repeat (50) @(negedge clk_hrc);
        end
        watch = 0;
        chk("R4 shortest phase", (min_ph >= 5) ? 5 : min_ph, 5);
        chk("R4 chain ends on RC", cur_src, 0);

        // R1 R6 random source and prescaler
        cur_exp = 0;
        for (int it = 0; it < 8; it++) begin
            s = $urandom % 4;
            dv = $urandom % 8;
            if (s == 1 && dv > 3) dv = 3;
            wr(2'd0, 8'(s)); wait_idle();
            wr(2'd1, 8'(dv)); repeat (10) @(negedge clk_hrc);
            chk("R1 random cur_src", cur_src, s);
            measure(per);
            chk("R6 random period", per, exp_per(s, dv));
        end

        // R9 peripheral enables
        for (int it = 0; it < 3; it++) begin
            pv = 8'($urandom);
            wr(2'd3, pv);
            chk("R9 per_clk_en", per_clk_en, pv);
        end

        // R7 R8 crystal failure with interrupt enabled
        wr(2'd1, 8'd0);
        wr(2'd2, 8'h03);
        wr(2'd0, 8'd2); wait_idle();
        repeat (200) @(negedge clk_hrc);
        chk("R7 healthy clock no fault", css_fault, 0);
        xtal_run = 0;
        repeat (300) @(negedge clk_hrc);
        chk("R7 fault on stopped crystal", css_fault, 1);
        chk("R8 irq enabled", css_irq, 1);
        wait_idle();
        chk("R7 fallback source", cur_src, 0);
        measure(per);
        chk("R7 fallback period", per, exp_per(0, 3));
        wr(2'd2, 8'h07);
        chk("R8 fault cleared", css_fault, 0);
        chk("R8 irq cleared", css_irq, 0);
        xtal_run = 1;

        // R8 external clock failure with interrupt disabled
        wr(2'd2, 8'h01);
        wr(2'd0, 8'd3); wait_idle();
        chk("R1 ext selected", cur_src, 3);
        ext_run = 0;
        repeat (300) @(negedge clk_hrc);
        chk("R7 fault on stopped ext", css_fault, 1);
        chk("R8 irq masked", css_irq, 0);
        wait_idle();
        wr(2'd2, 8'h05);
        ext_run = 1;

        // R7 monitor disabled: no fault
        wr(2'd2, 8'h00);
        wr(2'd0, 8'd2); wait_idle();
        chk("R7 crystal usable after fault", cur_src, 2);
        xtal_run = 0;
        repeat (300) @(negedge clk_hrc);
        chk("R7 monitor off no fault", css_fault, 0);
        chk("R7 monitor off stays", cur_src, 2);
        xtal_run = 1;
        wr(2'd0, 8'd0); wait_idle();
        chk("R3 back to RC", cur_src, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule